// File: doc/BRIEF.md
# Split OUT Payload Position Sequencer

This block steps through one full-speed OUT transfer that a high-speed host sends to a hub as a series of start-split payloads. Software loads the total byte count, the starting position code, the number of start-splits the transfer needs, a starting offset inside the first 4 KB page, and two page base pointers. From then on the block drives the tag, the length and the physical address for the next start-split on its outputs. Each issue strobe, one per microframe, retires one payload and advances the state.

A payload carries at most 188 bytes. The position code marks where a payload sits in the transfer. A transfer that fits in one payload is tagged All. A longer transfer is tagged Begin, then Mid for each inner payload, and then End. When the byte offset runs past the end of the first page, the address moves onto the second page pointer. A start-split count above six is an illegal configuration: it raises the error flag and freezes the sequence until the next load.

Top module: `split_out_seq`

## Requirements
- R1: While reset is held and in the cycle after it, pos_o is 00, len_o is 0, addr_o is 0, and done_o and err_o are 0.
- R2: One cycle after a load strobe, pos_o equals the loaded start code and addr_o equals the first page pointer in bits 31..12 joined with the loaded offset in bits 11..0. A load takes priority over an issue strobe in the same cycle.
- R3: len_o always equals the smaller of the remaining byte count and 188. Each accepted issue reduces the remaining count by the len_o value shown in the issue cycle.
- R4: The position codes are 00 All, 01 Begin, 10 Mid and 11 End. An accepted issue while the code is Begin or Mid moves it to End if 188 or fewer bytes remain after the payload, and to Mid otherwise. A two-payload transfer therefore goes from Begin directly to End.
- R5: An accepted issue leaves the codes All and End unchanged.
- R6: Each accepted issue lowers the start-split count by one. done_o is 1 when a loaded count has reached zero without error, a load with count 0 sets it at once, and while done_o is 1 an issue strobe changes no output.
- R7: A load with a start-split count greater than 6 sets err_o. While err_o is 1, done_o stays 0 and an issue strobe changes no output.
- R8: Each accepted issue advances addr_o bits 11..0 by the payload length, modulo 4096. When the advance passes 4095, addr_o bits 31..12 switch to the second page pointer and stay there for the rest of the transfer.
- R9: A new load fully replaces the previous transfer, including clearing err_o and done_o when the new configuration allows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Load a new transfer configuration |
| total_i | input | 16 | Total OUT byte count of the transfer |
| start_pos_i | input | 2 | Starting position code (00 All, 01 Begin, 10 Mid, 11 End) |
| splits_i | input | 3 | Number of start-splits the transfer needs |
| offset_i | input | 12 | Starting byte offset within the first page |
| page0_i | input | 20 | First 4 KB page pointer, physical address bits 31..12 |
| page1_i | input | 20 | Second 4 KB page pointer, physical address bits 31..12 |
| issue_i | input | 1 | One start-split has been issued this microframe |
| pos_o | output | 2 | Position code of the current payload |
| len_o | output | 8 | Byte length of the current payload |
| addr_o | output | 32 | Physical address of the current payload |
| done_o | output | 1 | Start-split count has reached zero |
| err_o | output | 1 | Illegal start-split count was loaded |

## Verification
All state is registered, and the outputs are decoded from it directly, so a wrong internal value shows at the ports on the negative edge right after the load or issue that caused it. A wrong remaining count shows as a wrong len_o at once, and as a wrong Mid/End choice one payload later. A lost carry on the offset shows as the wrong page bits on the first payload after the 4 KB crossing. A wrong start-split count shows as done_o rising one issue early or late.

// File: rtl/split_seq_pkg.sv
// Package: shared position-code type for the split OUT sequencer.
// Assumes: two-bit code; the numeric values are visible on the pos_o port.
package split_seq_pkg;
    typedef enum logic [1:0] {
        POS_ALL   = 2'b00,
        POS_BEGIN = 2'b01,
        POS_MID   = 2'b10,
        POS_END   = 2'b11
    } split_pos_e;
endpackage

// File: rtl/split_len_calc.sv
// Module: split_len_calc
// Computes the length of the next payload (capped at PAY_MAX), the byte
// count left after it, and whether that leftover fits in one payload.
// Assumes: purely combinational; PAY_W is wide enough to hold PAY_MAX.
module split_len_calc #(
    parameter int LEN_W   = 16,
    parameter int PAY_MAX = 188,
    parameter int PAY_W   = 8
) (
    input  logic [LEN_W-1:0] rem_i,
    output logic [PAY_W-1:0] pay_o,
    output logic [LEN_W-1:0] rem_next_o,
    output logic             rest_fits_o
);
    localparam logic [LEN_W-1:0] CAP = LEN_W'(PAY_MAX);

    // Cap the payload and derive the leftover byte count.
    always_comb begin
        if (rem_i > CAP) pay_o = PAY_W'(PAY_MAX);
        else             pay_o = rem_i[PAY_W-1:0];
        rem_next_o  = rem_i - {{(LEN_W-PAY_W){1'b0}}, pay_o};
        rest_fits_o = (rem_next_o <= CAP);
    end
endmodule

// File: rtl/split_pos_step.sv
// Module: split_pos_step
// Next position code after one payload has been retired.
// Assumes: All and End are terminal; Begin and Mid go to End once the
// leftover fits in a single payload, and to Mid otherwise.
module split_pos_step
    import split_seq_pkg::*;
(
    input  split_pos_e pos_i,
    input  logic       rest_fits_i,
    output split_pos_e pos_next_o
);
    // Pick the tag for the following payload.
    always_comb begin
        unique case (pos_i)
            POS_BEGIN, POS_MID: pos_next_o = rest_fits_i ? POS_END : POS_MID;
            default:            pos_next_o = pos_i;
        endcase
    end
endmodule

// File: rtl/split_addr_track.sv
// Module: split_addr_track
// Holds both page pointers and the running byte offset, and builds the
// physical address of the current payload.
// Assumes: a transfer crosses at most one page boundary, so a carry out of
// the offset only ever selects the second page.
module split_addr_track #(
    parameter int PAGE_W = 20,
    parameter int OFF_W  = 12,
    parameter int PAY_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic [PAGE_W-1:0]       page0_i,
    input  logic [PAGE_W-1:0]       page1_i,
    input  logic [OFF_W-1:0]        off_i,
    input  logic                    step_i,
    input  logic [PAY_W-1:0]        pay_i,
    output logic [PAGE_W+OFF_W-1:0] addr_o
);
    logic [PAGE_W-1:0] page0_q, page1_q;
    logic [OFF_W-1:0]  off_q;
    logic              sel_q;
    logic [OFF_W:0]    sum;

    // Offset plus payload, keeping the carry that marks a page crossing.
    always_comb sum = {1'b0, off_q} + {{(OFF_W+1-PAY_W){1'b0}}, pay_i};

    // Capture the pointers on load and advance the offset on each payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page0_q <= '0;
            page1_q <= '0;
            off_q   <= '0;
            sel_q   <= 1'b0;
        end else if (load_i) begin
            page0_q <= page0_i;
            page1_q <= page1_i;
            off_q   <= off_i;
            sel_q   <= 1'b0;
        end else if (step_i) begin
            off_q <= sum[OFF_W-1:0];
            if (sum[OFF_W]) sel_q <= 1'b1;
        end
    end

    // Join the selected page with the running offset.
    always_comb addr_o = {(sel_q ? page1_q : page0_q), off_q};
endmodule

// File: rtl/split_out_seq.sv
// Module: split_out_seq (top)
// Sequences the start-split payloads of one full-speed OUT transfer: it
// holds the remaining bytes, the position code and the start-split count,
// and presents tag, length and address of the next payload.
// Assumes: load_i wins over issue_i; issue_i is ignored when no payload is
// pending or an illegal count was loaded.
module split_out_seq
    import split_seq_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int PAY_MAX   = 188,
    parameter int CNT_W     = 3,
    parameter int CNT_LIMIT = 6,
    parameter int PAGE_W    = 20,
    parameter int OFF_W     = 12,
    parameter int PAY_W     = $clog2(PAY_MAX + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic [LEN_W-1:0]        total_i,
    input  logic [1:0]              start_pos_i,
    input  logic [CNT_W-1:0]        splits_i,
    input  logic [OFF_W-1:0]        offset_i,
    input  logic [PAGE_W-1:0]       page0_i,
    input  logic [PAGE_W-1:0]       page1_i,
    input  logic                    issue_i,
    output logic [1:0]              pos_o,
    output logic [PAY_W-1:0]        len_o,
    output logic [PAGE_W+OFF_W-1:0] addr_o,
    output logic                    done_o,
    output logic                    err_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CNT_LIMIT);

    logic [LEN_W-1:0] rem_q, rem_next;
    logic [CNT_W-1:0] cnt_q;
    split_pos_e       pos_q, pos_next;
    logic             loaded_q, err_q;
    logic             rest_fits, active, step;
    logic [PAY_W-1:0] pay;

    split_len_calc #(.LEN_W(LEN_W), .PAY_MAX(PAY_MAX), .PAY_W(PAY_W)) u_len (
        .rem_i       (rem_q),
        .pay_o       (pay),
        .rem_next_o  (rem_next),
        .rest_fits_o (rest_fits)
    );

    split_pos_step u_pos (
        .pos_i       (pos_q),
        .rest_fits_i (rest_fits),
        .pos_next_o  (pos_next)
    );

    split_addr_track #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .PAY_W(PAY_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .page0_i (page0_i),
        .page1_i (page1_i),
        .off_i   (offset_i),
        .step_i  (step),
        .pay_i   (pay),
        .addr_o  (addr_o)
    );

    // A payload is pending when a legal transfer still has start-splits.
    always_comb begin
        active = loaded_q && !err_q && (cnt_q != '0);
        step   = issue_i && active && !load_i;
    end

    // Transfer state: load the configuration, retire one payload per issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q    <= '0;
            cnt_q    <= '0;
            pos_q    <= POS_ALL;
            loaded_q <= 1'b0;
            err_q    <= 1'b0;
        end else if (load_i) begin
            rem_q    <= total_i;
            cnt_q    <= splits_i;
            pos_q    <= split_pos_e'(start_pos_i);
            loaded_q <= 1'b1;
            err_q    <= (splits_i > CNT_MAX);
        end else if (step) begin
            rem_q <= rem_next;
            cnt_q <= cnt_q - 1'b1;
            pos_q <= pos_next;
        end
    end

    // Output decode from registered state.
    always_comb begin
        pos_o  = pos_q;
        len_o  = pay;
        done_o = loaded_q && !err_q && (cnt_q == '0);
        err_o  = err_q;
    end
endmodule

// File: rtl/split_seq_chk.sv
// Module: split_seq_chk
// Port-level temporal checks for split_out_seq, attached by bind.
// Assumes: default parameter widths of the top module.
module split_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        load_i,
    input logic        issue_i,
    input logic [1:0]  pos_o,
    input logic [7:0]  len_o,
    input logic [31:0] addr_o,
    input logic        done_o,
    input logic        err_o
);
    logic took;
    // An issue that the block is expected to accept.
    always_comb took = issue_i && !load_i && !done_o && !err_o;

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pos_o == 2'b00 && len_o == 8'd0 && addr_o == 32'd0 && !done_o && !err_o));

    a_r3_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
        len_o <= 8'd188);

    a_r4_begin_next: assert property (@(posedge clk) disable iff (!rst_n)
        (took && pos_o == 2'b01) |=> (pos_o == 2'b10 || pos_o == 2'b11));

    a_r5_end_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && pos_o == 2'b11) |=> pos_o == 2'b11);

    a_r6_done_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !load_i) |=> (done_o && $stable(pos_o) && $stable(addr_o) && $stable(len_o)));

    a_r7_err_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !load_i) |=> (err_o && !done_o && $stable(pos_o) && $stable(addr_o)));

    a_r8_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
        took |=> addr_o[11:0] == 12'($past(addr_o[11:0]) + 12'($past(len_o))));
endmodule

bind split_out_seq split_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_i),
    .issue_i (issue_i),
    .pos_o   (pos_o),
    .len_o   (len_o),
    .addr_o  (addr_o),
    .done_o  (done_o),
    .err_o   (err_o)
);

// File: tb/split_out_seq_test.sv
// Bench for split_out_seq: directed corner cases plus seeded random
// transfers, each compared with a bench-side model of the requirements.
module split_out_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [15:0] total_i = '0;
    logic [1:0]  start_pos_i = '0;
    logic [2:0]  splits_i = '0;
    logic [11:0] offset_i = '0;
    logic [19:0] page0_i = '0;
    logic [19:0] page1_i = '0;
    logic        issue_i = 1'b0;
    logic [1:0]  pos_o;
    logic [7:0]  len_o;
    logic [31:0] addr_o;
    logic        done_o, err_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Model state
    int        m_rem, m_cnt, m_off;
    bit        m_sel, m_err, m_loaded;
    bit [1:0]  m_pos;
    bit [19:0] m_p0, m_p1;

    split_out_seq uut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .total_i(total_i),
        .start_pos_i(start_pos_i), .splits_i(splits_i), .offset_i(offset_i),
        .page0_i(page0_i), .page1_i(page1_i), .issue_i(issue_i),
        .pos_o(pos_o), .len_o(len_o), .addr_o(addr_o),
        .done_o(done_o), .err_o(err_o)
    );

    always #10 clk = ~clk;

    function automatic int exp_len(int rem);
        return (rem > 188) ? 188 : rem;
    endfunction

    function automatic bit [31:0] exp_addr();
        return {(m_sel ? m_p1 : m_p0), 12'(m_off)};
    endfunction

    function automatic bit exp_done();
        return m_loaded && !m_err && (m_cnt == 0);
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all(input string pos_req);
        chk(pos_req, pos_o, m_pos);
        chk("R3 len", len_o, exp_len(m_rem));
        chk("R8 addr", addr_o, exp_addr());
        chk("R6 done", done_o, exp_done());
        chk("R7 err", err_o, m_err);
    endtask

    task automatic do_load(input int tot, input bit [1:0] sp, input int cnt,
                           input int off, input bit [19:0] p0, input bit [19:0] p1);
        @(negedge clk);
        load_i = 1'b1; total_i = 16'(tot); start_pos_i = sp; splits_i = 3'(cnt);
        offset_i = 12'(off); page0_i = p0; page1_i = p1;
        @(negedge clk);
        load_i = 1'b0;
        m_rem = tot; m_pos = sp; m_cnt = cnt; m_off = off; m_sel = 0;
        m_p0 = p0; m_p1 = p1; m_err = (cnt > 6); m_loaded = 1;
        check_all("R2 R9 load");
    endtask

    task automatic do_issue();
        int l;
        @(negedge clk);
        issue_i = 1'b1;
        @(negedge clk);
        issue_i = 1'b0;
        if (m_loaded && !m_err && m_cnt != 0) begin
            l = exp_len(m_rem);
            m_rem -= l;
            m_cnt -= 1;
            if (m_off + l > 4095) m_sel = 1;
            m_off = (m_off + l) % 4096;
            if (m_pos == 2'b01 || m_pos == 2'b10)
                m_pos = (m_rem <= 188) ? 2'b11 : 2'b10;
        end
        check_all("R4 R5 issue");
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during and just after reset
        chk("R1 pos", pos_o, 0); chk("R1 len", len_o, 0); chk("R1 addr", addr_o, 0);
        chk("R1 done", done_o, 0); chk("R1 err", err_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle done", done_o, 0);

        // R5: single payload tagged All
        do_load(150, 2'b00, 1, 16, 20'h12345, 20'h54321);
        do_issue();
        chk("R6 single done", done_o, 1);
        chk("R5 all kept", pos_o, 2'b00);
        do_issue();  // R6: ignored once done
        chk("R6 addr frozen", addr_o, {20'h12345, 12'd166});

        // R4: two payloads go Begin straight to End
        do_load(300, 2'b01, 2, 0, 20'h00010, 20'h00020);
        do_issue();
        chk("R4 begin to end", pos_o, 2'b11);
        chk("R3 second len", len_o, 112);
        do_issue();

        // R4 R8: six payloads crossing the page boundary
        do_load(1100, 2'b01, 6, 4000, 20'hABCDE, 20'h13579);
        do_issue();
        chk("R4 begin to mid", pos_o, 2'b10);
        chk("R8 page switch", addr_o, {20'h13579, 12'd92});
        for (int i = 0; i < 5; i++) do_issue();
        chk("R6 six done", done_o, 1);

        // R7: illegal count, issue ignored, then R9 reload clears it
        do_load(400, 2'b01, 7, 8, 20'h00001, 20'h00002);
        chk("R7 err set", err_o, 1);
        do_issue();
        chk("R7 addr frozen", addr_o, {20'h00001, 12'd8});
        do_load(400, 2'b01, 3, 8, 20'h00001, 20'h00002);
        chk("R9 err cleared", err_o, 0);

        // R6: count zero is done at once
        do_load(100, 2'b00, 0, 0, 20'h00003, 20'h00004);
        chk("R6 zero count done", done_o, 1);

        // R2: load wins over a simultaneous issue
        @(negedge clk);
        load_i = 1'b1; issue_i = 1'b1; total_i = 16'd500; start_pos_i = 2'b01;
        splits_i = 3'd3; offset_i = 12'd44; page0_i = 20'h0BEEF; page1_i = 20'h0CAFE;
        @(negedge clk);
        load_i = 1'b0; issue_i = 1'b0;
        m_rem = 500; m_pos = 2'b01; m_cnt = 3; m_off = 44; m_sel = 0;
        m_p0 = 20'h0BEEF; m_p1 = 20'h0CAFE; m_err = 0; m_loaded = 1;
        check_all("R2 load priority");

        // Random transfers
        void'($urandom(32'd20240611));
        for (int t = 0; t < 300; t++) begin
            int tot, cnt, n;
            bit [1:0] sp;
            tot = 1 + ($urandom % 1128);
            cnt = (tot + 187) / 188;
            sp  = (tot <= 188) ? 2'b00 : 2'b01;
            if ($urandom % 6 == 0) cnt = $urandom % 8;
            if ($urandom % 8 == 0) sp = 2'($urandom);
            do_load(tot, sp, cnt, $urandom % 4096, 20'($urandom), 20'($urandom));
            n = $urandom % 8;
            for (int k = 0; k < n; k++) do_issue();
        end

        finish_run();
    end
endmodule